// File: doc/BRIEF.md
# Programmable External Memory Cycle Sequencer

This block turns single read or write requests from a core into timed bus cycles for an asynchronous external memory, such as a static RAM behind a chip select. Every bus cycle passes through three phases: lead (address and chip select set up), active (strobe low, optionally stretched by a ready input) and trail (hold after the strobe). The length of each phase comes from a 32-bit timing register that software writes, with separate fields for reads and for writes and one bit that doubles every phase.

The core side holds a request until it sees a one-cycle acknowledge, which also returns read data. The memory side drives an active-low chip select, separate active-low read and write strobes, the address, write data with an output enable, and a memory clock output. That clock runs either at the core rate or at half of it. In half-rate mode, cycles start only on its rising edge. The ready input can be ignored, used directly or passed through a two-flop synchronizer.

Top module: `ext_mem_seq`

## Requirements
- R1: Read lead is bits 13:12 and write lead is bits 6:5, where code n gives n clocks. Read active is bits 11:9 and write active is bits 4:2, where code n holds the strobe low for n+1 clocks. Read trail is bits 8:7 and write trail is bits 1:0, where code n gives n clocks. Chip select stays low for the sum of the three.
- R2: A read uses the read fields and lowers only rd_no during its active phase. A write uses the write fields and lowers only wr_no.
- R3: With bit 22 set, lead and trail become 2n clocks and the strobe lasts 2n+1 clocks.
- R4: With bit 14 clear, the ready input has no effect on cycle length.
- R5: With bit 14 set and bit 15 clear, ready_i is sampled directly. The strobe ends at the first clock edge, at or after the end of its programmed length, where ready_i is high.
- R6: With bits 14 and 15 set, ready_i passes through two flops first. A rise of ready_i therefore ends the strobe two clocks later than under R5.
- R7: With xclk_div2_i high, xclk_o toggles on every clock and chip select only falls together with a rising edge of xclk_o. With xclk_div2_i low, xclk_o follows clk_i.
- R8: After reset the bus is idle, cfg_err_o is low and the register holds 0x0043FFFF. In that state a read keeps chip select low for 27 clocks, and ready is in use in synchronized mode.
- R9: A register write with a lead code of 0 or with bits 17:16 other than binary 11 sets cfg_err_o, which stays high until reset. A lead code of 0 acts as 1.
- R10: A register write that arrives during a bus cycle does not change that cycle. It applies from the next cycle onward.
- R11: ack_o is high for exactly one clock, the first clock in which chip select is high again. On reads, rdata_o then holds the data sampled in the last strobe clock. No cycle starts while ack_o is high, and the two strobes are never low together.
- R12: During a write, mdata_oe_o is high and maddr_o and mdata_o stay constant for every clock that chip select is low. During a read, mdata_oe_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core and timing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xclk_div2_i | input | 1 | Memory clock at half rate when high |
| cfg_we_i | input | 1 | Timing register write enable |
| cfg_wdata_i | input | 32 | Timing register write value |
| cfg_err_o | output | 1 | Sticky illegal configuration flag |
| req_i | input | 1 | Transfer request, held until ack |
| req_we_i | input | 1 | High for write, low for read |
| req_addr_i | input | AW | Transfer address |
| req_wdata_i | input | DW | Write data |
| ack_o | output | 1 | One-cycle transfer completion |
| rdata_o | output | DW | Read data, valid with ack |
| xclk_o | output | 1 | Memory clock output |
| cs_no | output | 1 | Chip select, active low |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| maddr_o | output | AW | Memory address |
| mdata_o | output | DW | Memory write data |
| mdata_oe_o | output | 1 | Write data output enable |
| mdata_i | input | DW | Memory read data |
| ready_i | input | 1 | Memory ready, stretches the strobe |

## Verification
The hardest case to reach from the ports is ready going high in a known clock relative to the strobe, because the release cycle decides the whole cycle length and differs by two clocks between the two sampling modes. The bench holds ready low, counts strobe-low clocks at the falling clock edge, and raises ready in a chosen strobe clock, so the expected strobe length is exact in both modes. A register write that lands in the middle of a long cycle is the other awkward case. It is reached by running the transfer and the register write in parallel threads and checking the lengths of two consecutive cycles.

// File: rtl/ems_pkg.sv
package ems_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_LEAD, PH_ACT, PH_TRAIL} phase_e;

  localparam int          CfgW     = 32;
  localparam int          LenW     = 4;   // longest phase: (7<<1)+1
  localparam logic [31:0] CFG_MASK = 32'h0043_FFFF;
  localparam logic [31:0] CFG_RST  = 32'h0043_FFFF;

  typedef struct packed {
    logic [LenW-1:0] lead;
    logic [LenW-1:0] act;
    logic [LenW-1:0] trail;
  } lens_t;

  function automatic lens_t cfg_lens(input logic [CfgW-1:0] c, input logic wr);
    logic [1:0]      ld;
    logic [1:0]      tr;
    logic [2:0]      ac;
    logic [LenW-1:0] l;
    lens_t           r;
    ld = wr ? c[6:5] : c[13:12];
    ac = wr ? c[4:2] : c[11:9];
    tr = wr ? c[1:0] : c[8:7];
    l  = (ld == 2'd0) ? LenW'(1) : LenW'(ld);
    r.lead  = l << c[22];
    r.act   = (LenW'(ac) << c[22]) + LenW'(1);
    r.trail = LenW'(tr) << c[22];
    return r;
  endfunction

  function automatic logic cfg_bad(input logic [CfgW-1:0] c);
    return (c[13:12] == 2'd0) || (c[6:5] == 2'd0) || (c[17:16] != 2'b11);
  endfunction
endpackage

// File: rtl/ems_cfg_reg.sv
module ems_cfg_reg
  import ems_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [CfgW-1:0] wdata_i,
  output logic [CfgW-1:0] cfg_o,
  output logic            err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= CFG_RST;
      err_o <= 1'b0;
    end else if (we_i) begin
      cfg_o <= wdata_i & CFG_MASK;
      if (cfg_bad(wdata_i)) err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/ems_clkgen.sv
module ems_clkgen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic div2_i,
  output logic xclk_o,
  output logic start_ok_o
);
  logic tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= 1'b0;
    else         tog_q <= !tog_q;
  end

  assign xclk_o     = div2_i ? tog_q : clk_i;
  // next edge raises tog_q: a cycle started now begins on a rising xclk
  assign start_ok_o = !div2_i || !tog_q;
endmodule

// File: rtl/ems_rdy_sync.sv
module ems_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ready_i,
  input  logic async_i,
  output logic rdy_o
);
  logic [STAGES-1:0] sq;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sq <= '0;
      else         sq <= ready_i;
    end
  end else begin : g_many
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sq <= '0;
      else         sq <= {sq[STAGES-2:0], ready_i};
    end
  end

  assign rdy_o = async_i ? sq[STAGES-1] : ready_i;
endmodule

// File: rtl/ext_mem_seq.sv
module ext_mem_seq
  import ems_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            xclk_div2_i,
  input  logic            cfg_we_i,
  input  logic [CfgW-1:0] cfg_wdata_i,
  output logic            cfg_err_o,
  input  logic            req_i,
  input  logic            req_we_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [DW-1:0]   req_wdata_i,
  output logic            ack_o,
  output logic [DW-1:0]   rdata_o,
  output logic            xclk_o,
  output logic            cs_no,
  output logic            rd_no,
  output logic            wr_no,
  output logic [AW-1:0]   maddr_o,
  output logic [DW-1:0]   mdata_o,
  output logic            mdata_oe_o,
  input  logic [DW-1:0]   mdata_i,
  input  logic            ready_i
);
  phase_e          st_q;
  logic [LenW-1:0] cnt_q;
  logic [CfgW-1:0] cfg_q, cur_q;
  logic            cur_we_q, ack_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wd_q, rd_q;
  logic            start_ok, rdy_eff, rdy_go, start;
  lens_t           new_l, cur_l;

  ems_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg_q),
    .err_o   (cfg_err_o)
  );

  ems_clkgen u_clk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .div2_i     (xclk_div2_i),
    .xclk_o     (xclk_o),
    .start_ok_o (start_ok)
  );

  ems_rdy_sync #(.STAGES(SYNC_STAGES)) u_rdy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ready_i (ready_i),
    .async_i (cur_q[15]),
    .rdy_o   (rdy_eff)
  );

  assign new_l  = cfg_lens(cfg_q, req_we_i);
  assign cur_l  = cfg_lens(cur_q, cur_we_q);
  assign rdy_go = !cur_q[14] || rdy_eff;
  assign start  = (st_q == PH_IDLE) && req_i && !ack_q && start_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= PH_IDLE;
      cnt_q    <= '0;
      cur_q    <= CFG_RST;
      cur_we_q <= 1'b0;
      ack_q    <= 1'b0;
      addr_q   <= '0;
      wd_q     <= '0;
      rd_q     <= '0;
    end else begin
      ack_q <= 1'b0;
      unique case (st_q)
        PH_IDLE: if (start) begin
          st_q     <= PH_LEAD;
          cnt_q    <= new_l.lead - 1'b1;
          cur_q    <= cfg_q;  // config frozen for the whole cycle
          cur_we_q <= req_we_i;
          addr_q   <= req_addr_i;
          wd_q     <= req_wdata_i;
        end
        PH_LEAD: if (cnt_q == '0) begin
          st_q  <= PH_ACT;
          cnt_q <= cur_l.act - 1'b1;
        end else cnt_q <= cnt_q - 1'b1;
        PH_ACT: if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        else if (rdy_go) begin
          if (!cur_we_q) rd_q <= mdata_i;
          if (cur_l.trail == '0) begin
            st_q  <= PH_IDLE;
            ack_q <= 1'b1;
          end else begin
            st_q  <= PH_TRAIL;
            cnt_q <= cur_l.trail - 1'b1;
          end
        end
        PH_TRAIL: if (cnt_q == '0) begin
          st_q  <= PH_IDLE;
          ack_q <= 1'b1;
        end else cnt_q <= cnt_q - 1'b1;
      endcase
    end
  end

  assign cs_no      = (st_q == PH_IDLE);
  assign rd_no      = !((st_q == PH_ACT) && !cur_we_q);
  assign wr_no      = !((st_q == PH_ACT) && cur_we_q);
  assign mdata_oe_o = (st_q != PH_IDLE) && cur_we_q;
  assign mdata_o    = wd_q;
  assign maddr_o    = addr_q;
  assign ack_o      = ack_q;
  assign rdata_o    = rd_q;
endmodule

// File: rtl/ext_mem_seq_chk.sv
module ext_mem_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          xclk_div2_i,
  input logic          xclk_o,
  input logic          cs_no,
  input logic          rd_no,
  input logic          wr_no,
  input logic          ack_o,
  input logic          mdata_oe_o,
  input logic          cfg_err_o,
  input logic [AW-1:0] maddr_o
);
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no)); // R11
  AST_STROBE_IN_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !wr_no) |-> !cs_no); // R11
  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o); // R11
  AST_ACK_AFTER_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> cs_no && $past(!cs_no)); // R11
  AST_NO_START_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> cs_no); // R11
  AST_OE_IN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdata_oe_o |-> !cs_no && rd_no); // R12
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && $past(!cs_no)) |-> $stable(maddr_o)); // R12
  AST_START_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xclk_div2_i && $fell(cs_no)) |-> xclk_o); // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o); // R9
endmodule

bind ext_mem_seq ext_mem_seq_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .xclk_div2_i (xclk_div2_i),
  .xclk_o      (xclk_o),
  .cs_no       (cs_no),
  .rd_no       (rd_no),
  .wr_no       (wr_no),
  .ack_o       (ack_o),
  .mdata_oe_o  (mdata_oe_o),
  .cfg_err_o   (cfg_err_o),
  .maddr_o     (maddr_o)
);

// File: tb/ext_mem_seq_bench.sv
`timescale 1ns/1ps
module ext_mem_seq_bench;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam logic [31:0] MASK = 32'h0043_FFFF;

  logic clk = 1'b0, rst_n = 1'b0, div2 = 1'b0;
  logic cfg_we = 1'b0, req = 1'b0, req_we = 1'b0, ready = 1'b0;
  logic [31:0] cfg_wd = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wd = '0;
  logic cfg_err, ack, xclk, cs_n, rd_n, wr_n, oe;
  logic [DW-1:0] rdata, mdo, mdi;
  logic [AW-1:0] maddr;

  int n_chk = 0, n_err = 0;
  bit live = 0, done = 0;
  logic [DW-1:0] ram [256];

  always #2.5 clk = ~clk;

  ext_mem_seq #(.AW(AW), .DW(DW)) u_ext_mem_seq (
    .clk_i(clk), .rst_ni(rst_n), .xclk_div2_i(div2),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd), .cfg_err_o(cfg_err),
    .req_i(req), .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wd),
    .ack_o(ack), .rdata_o(rdata), .xclk_o(xclk), .cs_no(cs_n), .rd_no(rd_n),
    .wr_no(wr_n), .maddr_o(maddr), .mdata_o(mdo), .mdata_oe_o(oe),
    .mdata_i(mdi), .ready_i(ready));

  // behavioural memory
  initial for (int i = 0; i < 256; i++) ram[i] = DW'(i * 37 + 11);
  assign mdi = ram[maddr[7:0]];
  always @(posedge clk) if (!wr_n) ram[maddr[7:0]] <= mdo;

  task automatic chk(input bit ok, input string tag, input longint a, input longint e);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, a, e);
    end
  endtask

  function automatic bit [31:0] mk(int rl, int ra, int rt, int wl, int wa, int wt,
                                   int ren, int rm, int dbl, int sz);
    return 32'(wt | (wa << 2) | (wl << 5) | (rt << 7) | (ra << 9) | (rl << 12) |
               (ren << 14) | (rm << 15) | (sz << 16) | (dbl << 22));
  endfunction
  function automatic int f_lead(bit [31:0] c, bit w);
    int k = w ? int'(c[6:5]) : int'(c[13:12]);
    if (k == 0) k = 1;
    return c[22] ? 2 * k : k;
  endfunction
  function automatic int f_act(bit [31:0] c, bit w);
    int k = w ? int'(c[4:2]) : int'(c[11:9]);
    return (c[22] ? 2 * k : k) + 1;
  endfunction
  function automatic int f_trail(bit [31:0] c, bit w);
    int k = w ? int'(c[1:0]) : int'(c[8:7]);
    return c[22] ? 2 * k : k;
  endfunction
  function automatic int f_len(bit [31:0] c, bit w);
    return f_lead(c, w) + f_act(c, w) + f_trail(c, w);
  endfunction

  // cycle reference model
  int m_ph, m_left;
  bit m_ack, m_we, m_err, m_xclk, m_rs1, m_rs2;
  bit [31:0] m_cfg, m_cur;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wd, m_rd;

  always @(posedge clk) begin
    bit rdy_now, nack;
    if (!rst_n) begin
      m_ph = 0; m_left = 0; m_ack = 0; m_we = 0; m_err = 0; m_xclk = 0;
      m_rs1 = 0; m_rs2 = 0; m_cfg = MASK; m_cur = MASK; m_addr = '0; m_wd = '0; m_rd = '0;
    end else begin
      rdy_now = m_cur[15] ? m_rs2 : ready;
      nack = 0;
      case (m_ph)
        0: if (req && !m_ack && (!div2 || !m_xclk)) begin
          m_cur = m_cfg; m_we = req_we; m_addr = req_addr; m_wd = req_wd;
          m_ph = 1; m_left = f_lead(m_cur, m_we) - 1;
        end
        1: if (m_left == 0) begin m_ph = 2; m_left = f_act(m_cur, m_we) - 1; end
           else m_left--;
        2: if (m_left != 0) m_left--;
           else if (!m_cur[14] || rdy_now) begin
             if (!m_we) m_rd = ram[m_addr[7:0]];
             if (f_trail(m_cur, m_we) == 0) begin m_ph = 0; nack = 1; end
             else begin m_ph = 3; m_left = f_trail(m_cur, m_we) - 1; end
           end
        default: if (m_left == 0) begin m_ph = 0; nack = 1; end else m_left--;
      endcase
      m_ack = nack; m_rs2 = m_rs1; m_rs1 = ready; m_xclk = !m_xclk;
      if (cfg_we) begin
        m_cfg = cfg_wd & MASK;
        if (cfg_wd[13:12] == 0 || cfg_wd[6:5] == 0 || cfg_wd[17:16] != 2'b11) m_err = 1;
      end
    end
  end

  always @(negedge clk) if (rst_n && live && !done) begin
    chk(cs_n == (m_ph == 0), "R1 chip select", cs_n, m_ph == 0);
    chk(rd_n == !(m_ph == 2 && !m_we), "R2 read strobe", rd_n, !(m_ph == 2 && !m_we));
    chk(wr_n == !(m_ph == 2 && m_we), "R2 write strobe", wr_n, !(m_ph == 2 && m_we));
    chk(ack == m_ack, "R11 ack", ack, m_ack);
    if (m_ack && !m_we) chk(rdata == m_rd, "R11 read data", rdata, m_rd);
    chk(oe == (m_ph != 0 && m_we), "R12 output enable", oe, m_ph != 0 && m_we);
    if (m_ph != 0) chk(maddr == m_addr, "R12 address", maddr, m_addr);
    if (m_ph != 0 && m_we) chk(mdo == m_wd, "R12 write data", mdo, m_wd);
    chk(cfg_err == m_err, "R9 error flag", cfg_err, m_err);
  end

  task automatic cfg_write(input bit [31:0] v);
    @(negedge clk); cfg_we = 1; cfg_wd = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic xfer(input bit w, input int a, input int d, output int len,
                      output int strobes, output bit xs, output logic [DW-1:0] q);
    len = 0; strobes = 0; xs = 0;
    @(negedge clk); req = 1; req_we = w; req_addr = AW'(a); req_wd = DW'(d);
    forever begin
      @(negedge clk);
      if (!cs_n) begin if (len == 0) xs = xclk; len++; end
      if (!rd_n || !wr_n) strobes++;
      if (ack) break;
    end
    q = rdata; req = 0;
  endtask

  task automatic finish_run;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int len, sb, len2; bit xs; logic [DW-1:0] q; bit [31:0] c, c2;
    repeat (3) @(negedge clk);
    rst_n = 1; live = 1;
    @(negedge clk);
    chk(cs_n && rd_n && wr_n && !ack, "R8 idle after reset", {cs_n, rd_n, wr_n, ack}, 4'b1110);
    chk(!cfg_err, "R8 error clear after reset", cfg_err, 0);

    ready = 1;
    repeat (3) @(negedge clk);
    xfer(0, 5, 0, len, sb, xs, q);
    chk(len == 27, "R8 reset cycle length", len, 27);
    chk(q == ram[5], "R11 reset read data", q, ram[5]);

    c = mk(1, 3, 0, 1, 2, 1, 0, 0, 0, 3);
    cfg_write(c);
    xfer(1, 10, 16'hA5C3, len, sb, xs, q);
    chk(len == 5, "R2 write length", len, 5);
    chk(sb == 3, "R2 write strobe length", sb, 3);
    xfer(0, 10, 0, len, sb, xs, q);
    chk(len == 5, "R2 read length", len, 5);
    chk(q == 16'hA5C3, "R11 read back", q, 16'hA5C3);

    for (int dbl = 0; dbl < 2; dbl++)
      for (int rl = 1; rl < 4; rl++)
        for (int k = 0; k < 3; k++) begin
          int ra = (k * 3 + rl) % 8, rt = (rl + k) % 4;
          int ad = 32 + dbl * 16 + rl * 4 + k;
          int dv = ad * 257 + 5;
          c = mk(rl, ra, rt, 4 - rl, 7 - ra, 3 - rt, 0, 0, dbl, 3);
          cfg_write(c);
          xfer(1, ad, dv, len, sb, xs, q);
          chk(len == f_len(c, 1), dbl ? "R3 doubled write length" : "R1 write length",
              len, f_len(c, 1));
          chk(sb == f_act(c, 1), dbl ? "R3 doubled write strobe" : "R1 write strobe",
              sb, f_act(c, 1));
          xfer(0, ad, 0, len, sb, xs, q);
          chk(len == f_len(c, 0), dbl ? "R3 doubled read length" : "R1 read length",
              len, f_len(c, 0));
          chk(q == DW'(dv), "R11 pattern read data", q, DW'(dv));
        end

    // R4: ready ignored
    c = mk(2, 2, 1, 1, 1, 1, 0, 0, 0, 3);
    cfg_write(c);
    ready = 0;
    xfer(0, 7, 0, len, sb, xs, q);
    chk(len == f_len(c, 0), "R4 ready ignored", len, f_len(c, 0));

    // R5: direct ready
    c = mk(1, 1, 1, 1, 1, 1, 1, 0, 0, 3);
    cfg_write(c);
    ready = 1;
    xfer(0, 8, 0, len, sb, xs, q);
    chk(sb == 2, "R5 ready high no stretch", sb, 2);
    ready = 0;
    repeat (3) @(negedge clk);
    fork
      xfer(0, 9, 0, len, sb, xs, q);
      begin
        int s = 0;
        while (s < 6) begin @(negedge clk); if (!rd_n) s++; end
        ready = 1;
      end
    join
    chk(sb == 6, "R5 direct ready strobe", sb, 6);
    chk(len == 8, "R5 direct ready length", len, 8);
    chk(q == ram[9], "R5 stretched read data", q, ram[9]);

    // R6: synchronized ready
    c = mk(1, 1, 1, 1, 1, 1, 1, 1, 0, 3);
    cfg_write(c);
    repeat (3) @(negedge clk);
    xfer(0, 8, 0, len, sb, xs, q);
    chk(sb == 2, "R6 settled ready no stretch", sb, 2);
    ready = 0;
    repeat (3) @(negedge clk);
    fork
      xfer(1, 12, 16'h0BEE, len, sb, xs, q);
      begin
        int s = 0;
        while (s < 6) begin @(negedge clk); if (!wr_n) s++; end
        ready = 1;
      end
    join
    chk(sb == 8, "R6 synchronized ready strobe", sb, 8);

    // R7: half-rate memory clock
    c = mk(1, 0, 0, 2, 1, 0, 0, 0, 0, 3);
    cfg_write(c);
    @(negedge clk); div2 = 1;
    for (int i = 0; i < 4; i++) begin
      xfer(i[0], 40 + i, i * 9, len, sb, xs, q);
      chk(xs == 1'b1, "R7 start on rising memory clock", xs, 1);
      chk(len == f_len(c, i[0]), "R7 length at half rate", len, f_len(c, i[0]));
    end
    @(negedge clk); div2 = 0;

    // R10: register write during a cycle
    c = mk(3, 7, 3, 1, 1, 1, 0, 0, 0, 3);
    c2 = mk(1, 0, 0, 1, 0, 0, 0, 0, 0, 3);
    cfg_write(c);
    fork
      xfer(0, 3, 0, len, sb, xs, q);
      begin repeat (4) @(negedge clk); cfg_write(c2); end
    join
    xfer(0, 4, 0, len2, sb, xs, q);
    chk(len == 14, "R10 running cycle unchanged", len, 14);
    chk(len2 == 2, "R10 next cycle uses new value", len2, 2);

    // R9: lead code 0 and size field
    c = mk(0, 2, 1, 1, 1, 1, 0, 0, 0, 3);
    cfg_write(c);
    chk(cfg_err, "R9 lead zero flags error", cfg_err, 1);
    xfer(0, 6, 0, len, sb, xs, q);
    chk(len == 1 + 3 + 1, "R9 lead zero acts as one", len, 5);
    cfg_write(mk(1, 1, 1, 1, 1, 1, 0, 0, 0, 3));
    repeat (2) @(negedge clk);
    chk(cfg_err, "R9 error is sticky", cfg_err, 1);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!cfg_err, "R8 reset clears error", cfg_err, 0);
    cfg_write(mk(1, 1, 1, 1, 1, 1, 0, 0, 0, 2));
    chk(cfg_err, "R9 size field flags error", cfg_err, 1);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule